// File: doc/BRIEF.md
# Synchronous Frame Reference Current Generator

This block turns one set of sampled three-phase load currents into the three phase currents that a shunt compensator should inject. Each accepted sample starts one pass. The pass projects the load currents onto a rotating d-q frame, using a sine/cosine pair supplied with the sample. It removes the slowly varying (mean) part of the d component with a short low-pass filter. It then subtracts a loss term that a PI regulator derives from the DC link voltage error. The q component is kept whole. The result is rotated back and expanded to three phases, and the zero-sequence part of the load is carried through unchanged. After compensation, the supply is left carrying only the mean active current plus the losses of the converter.

Samples enter through a valid/ready handshake and results leave through a second one. The block holds one sample at a time. `in_ready` is high only when the block is idle and no result is waiting to be read. A finished result stays on the output pins until the consumer takes it, and a sample offered during that time is not taken. The PI limit is a plain control pin that is changed only while reset is asserted. All data words are signed two's complement integers. Every constant is Q2.14, every product is scaled back by an arithmetic right shift of 14 bits (floor), and the angle pair must be a unit vector in Q2.14.

Top module: `srf_refgen`

## Requirements
- R1: A synchronous reset clears the three filter history taps, the PI integrator and the loss term. It drives `out_valid` to 0, `in_ready` to 1 and all three references to 0.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until the result has been handed over, and `in_valid` has no effect during that time.
- R3: `out_valid` rises on the sixth rising edge after the accepting edge. This is exactly one cycle after the reference outputs load.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and the three references hold their values. The edge where both are 1 clears `out_valid`, and `in_ready` returns on that edge.
- R5: The forward Clarke step computes alpha = (5456·(2a−b−c))>>14, beta = (9450·(b−c))>>14 and zero = (5456·(a+b+c))>>14.
- R6: The forward rotation computes d = (cos·alpha + sin·beta)>>14 and q = (cos·beta − sin·alpha)>>14.
- R7: The mean of d is m = (1167·(d0+d3) + 7025·(d1+d2))>>14. Here d0 is the current pass and d1..d3 are the three previous passes since reset. The coefficients sum to 16384, so a constant d gives m = d from the fourth pass on.
- R8: With e = vdc_set − vdc_meas, the integrator I becomes clamp(I + 19497·e, ±L·16384) once per pass. The loss term is clamp((9830·e + I)>>14, ±L), where L is `pi_limit`.
- R9: The d reference is d − m − loss, and the q reference is q unchanged.
- R10: The inverse rotation computes a* = (cos·dref − sin·q)>>14 and b* = (sin·dref + cos·q)>>14. The outputs are ref_a = zero + a*, ref_b = zero − (a*>>1) + r and ref_c = zero − (a*>>1) − r, where r = (14189·b*)>>14. Each output saturates to [−32768, 32767].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| load_a | input | 16 | Phase a load current, signed |
| load_b | input | 16 | Phase b load current, signed |
| load_c | input | 16 | Phase c load current, signed |
| vdc_meas | input | 16 | Measured DC link voltage, signed |
| vdc_set | input | 16 | DC link voltage setpoint, signed |
| ang_cos | input | 16 | Cosine of the synchronizing angle, Q2.14 |
| ang_sin | input | 16 | Sine of the synchronizing angle, Q2.14 |
| pi_limit | input | 16 | PI limit L, unsigned, at most 32767 |
| out_valid | output | 1 | Result available (done strobe) |
| out_ready | input | 1 | Consumer takes the result |
| ref_a | output | 16 | Phase a compensator reference |
| ref_b | output | 16 | Phase b compensator reference |
| ref_c | output | 16 | Phase c compensator reference |

## Verification
The bench feeds a constant d current four times after reset and expects exactly zero output on the fourth pass. A filter whose coefficients do not sum to unity, or whose history shifts in the wrong order, leaves a nonzero residue there. It drives the PI into its limit and then reverses the error. The loss must come off the clamp within one pass, which a design that let the integrator wind past its bound would fail to do. It also checks that an equal-phase sample gives three identical references equal to the zero-sequence term. A large loss must clip ref_a to −32768 rather than wrap. Finally, it offers a different sample while a result is held back, and the following pass must match a history that never saw that sample.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
  localparam int FRAC = 14;
  localparam int AW   = 48;
  typedef logic signed [AW-1:0] acc_t;

  localparam acc_t K_THIRD = 48'sd5456;   // one third, Q2.14
  localparam acc_t K_BETA  = 48'sd9450;   // 0.666 * 0.866
  localparam acc_t K_R3H   = 48'sd14189;  // 0.866
  localparam acc_t K_LP_O  = 48'sd1167;   // outer filter taps
  localparam acc_t K_LP_I  = 48'sd7025;   // inner filter taps
  localparam acc_t K_P     = 48'sd9830;   // 0.6
  localparam acc_t K_I     = 48'sd19497;  // 1.19

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLARKE, ST_PARK, ST_FILT, ST_INV, ST_OUT, ST_FLAG, ST_HOLD
  } stage_t;

  function automatic acc_t sat(input acc_t v, input acc_t hi, input acc_t lo);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/srf_clarke.sv
`timescale 1ns/1ps
module srf_clarke
  import srf_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = W + 6
) (
  input  logic signed [W-1:0]  xa,
  input  logic signed [W-1:0]  xb,
  input  logic signed [W-1:0]  xc,
  output logic signed [IW-1:0] alpha,
  output logic signed [IW-1:0] beta,
  output logic signed [IW-1:0] zero
);
  acc_t a, b, c;
  always_comb begin
    a = acc_t'(xa);
    b = acc_t'(xb);
    c = acc_t'(xc);
    alpha = IW'((K_THIRD * (a + a - b - c)) >>> FRAC);
    beta  = IW'((K_BETA * (b - c)) >>> FRAC);
    zero  = IW'((K_THIRD * (a + b + c)) >>> FRAC);
  end
endmodule

// File: rtl/srf_rotate.sv
`timescale 1ns/1ps
module srf_rotate
  import srf_pkg::*;
#(
  parameter int W   = 16,
  parameter int IW  = W + 6,
  parameter bit INV = 1'b0
) (
  input  logic signed [IW-1:0] x,
  input  logic signed [IW-1:0] y,
  input  logic signed [W-1:0]  c,
  input  logic signed [W-1:0]  s,
  output logic signed [IW-1:0] u,
  output logic signed [IW-1:0] v
);
  acc_t xe, ye, ce, se;
  always_comb begin
    xe = acc_t'(x);
    ye = acc_t'(y);
    ce = acc_t'(c);
    se = acc_t'(s);
  end

  generate
    if (INV) begin : g_back
      always_comb begin
        u = IW'((ce * xe - se * ye) >>> FRAC);
        v = IW'((se * xe + ce * ye) >>> FRAC);
      end
    end else begin : g_fwd
      always_comb begin
        u = IW'((ce * xe + se * ye) >>> FRAC);
        v = IW'((ce * ye - se * xe) >>> FRAC);
      end
    end
  endgenerate
endmodule

// File: rtl/srf_dc_lpf.sv
`timescale 1ns/1ps
module srf_dc_lpf
  import srf_pkg::*;
#(
  parameter int IW = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic signed [IW-1:0] x,
  output logic signed [IW-1:0] mean
);
  localparam int NTAP = 4;
  localparam int NHIST = NTAP - 1;

  logic signed [IW-1:0] hist_q [NHIST];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NHIST; k++) hist_q[k] <= '0;
    end else if (en) begin
      hist_q[0] <= x;
      for (int k = 1; k < NHIST; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  always_comb begin
    mean = IW'((K_LP_O * (acc_t'(x) + acc_t'(hist_q[NHIST-1]))
              + K_LP_I * (acc_t'(hist_q[0]) + acc_t'(hist_q[1]))) >>> FRAC);
  end
endmodule

// File: rtl/srf_pi.sv
`timescale 1ns/1ps
module srf_pi
  import srf_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = W + 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W:0]   err,
  input  logic [W-1:0]        lim,
  output logic signed [IW-1:0] loss
);
  acc_t integ_q, integ_d, bound_o, bound_i, raw;

  always_comb begin
    bound_o = acc_t'(lim);
    bound_i = bound_o <<< FRAC;
    integ_d = sat(integ_q + K_I * acc_t'(err), bound_i, -bound_i);
    raw     = (K_P * acc_t'(err) + integ_d) >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      loss    <= '0;
    end else if (en) begin
      integ_q <= integ_d;
      loss    <= IW'(sat(raw, bound_o, -bound_o));
    end
  end
endmodule

// File: rtl/srf_refgen.sv
`timescale 1ns/1ps
module srf_refgen
  import srf_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = W + 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] load_a,
  input  logic signed [W-1:0] load_b,
  input  logic signed [W-1:0] load_c,
  input  logic signed [W-1:0] vdc_meas,
  input  logic signed [W-1:0] vdc_set,
  input  logic signed [W-1:0] ang_cos,
  input  logic signed [W-1:0] ang_sin,
  input  logic [W-1:0]        pi_limit,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] ref_a,
  output logic signed [W-1:0] ref_b,
  output logic signed [W-1:0] ref_c
);
  localparam acc_t OUT_HI = acc_t'((longint'(1) <<< (W - 1)) - 1);
  localparam acc_t OUT_LO = -OUT_HI - 48'sd1;

  stage_t st;

  logic signed [W-1:0]  la_q, lb_q, lc_q, vm_q, vs_q, cos_q, sin_q;
  logic signed [IW-1:0] alpha_q, beta_q, zero_q, id_q, iq_q, dref_q, ar_q, br_q;
  logic signed [IW-1:0] alpha_w, beta_w, zero_w, id_w, iq_w, ar_w, br_w;
  logic signed [IW-1:0] mean_w, loss_w;
  logic signed [W:0]    err_w;
  acc_t half_w, r3_w, ra_w, rb_w, rc_w;

  assign in_ready = (st == ST_IDLE);
  assign err_w    = (W+1)'(vs_q) - (W+1)'(vm_q);

  srf_clarke #(.W(W), .IW(IW)) u_clarke (
    .xa(la_q), .xb(lb_q), .xc(lc_q),
    .alpha(alpha_w), .beta(beta_w), .zero(zero_w)
  );

  srf_rotate #(.W(W), .IW(IW), .INV(1'b0)) u_park (
    .x(alpha_q), .y(beta_q), .c(cos_q), .s(sin_q), .u(id_w), .v(iq_w)
  );

  srf_pi #(.W(W), .IW(IW)) u_pi (
    .clk(clk), .rst(rst), .en(st == ST_PARK),
    .err(err_w), .lim(pi_limit), .loss(loss_w)
  );

  srf_dc_lpf #(.IW(IW)) u_lpf (
    .clk(clk), .rst(rst), .en(st == ST_FILT), .x(id_q), .mean(mean_w)
  );

  srf_rotate #(.W(W), .IW(IW), .INV(1'b1)) u_ipark (
    .x(dref_q), .y(iq_q), .c(cos_q), .s(sin_q), .u(ar_w), .v(br_w)
  );

  // inverse Clarke with output saturation
  always_comb begin
    half_w = acc_t'(ar_q) >>> 1;
    r3_w   = (K_R3H * acc_t'(br_q)) >>> FRAC;
    ra_w   = sat(acc_t'(zero_q) + acc_t'(ar_q), OUT_HI, OUT_LO);
    rb_w   = sat(acc_t'(zero_q) - half_w + r3_w, OUT_HI, OUT_LO);
    rc_w   = sat(acc_t'(zero_q) - half_w - r3_w, OUT_HI, OUT_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      out_valid <= 1'b0;
      la_q <= '0; lb_q <= '0; lc_q <= '0;
      vm_q <= '0; vs_q <= '0; cos_q <= '0; sin_q <= '0;
      alpha_q <= '0; beta_q <= '0; zero_q <= '0;
      id_q <= '0; iq_q <= '0; dref_q <= '0; ar_q <= '0; br_q <= '0;
      ref_a <= '0; ref_b <= '0; ref_c <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (in_valid) begin
          la_q  <= load_a;   lb_q  <= load_b;  lc_q <= load_c;
          vm_q  <= vdc_meas; vs_q  <= vdc_set;
          cos_q <= ang_cos;  sin_q <= ang_sin;
          st    <= ST_CLARKE;
        end
        ST_CLARKE: begin
          alpha_q <= alpha_w; beta_q <= beta_w; zero_q <= zero_w;
          st      <= ST_PARK;
        end
        ST_PARK: begin
          id_q <= id_w; iq_q <= iq_w;
          st   <= ST_FILT;
        end
        ST_FILT: begin
          dref_q <= id_q - mean_w - loss_w;
          st     <= ST_INV;
        end
        ST_INV: begin
          ar_q <= ar_w; br_q <= br_w;
          st   <= ST_OUT;
        end
        ST_OUT: begin
          ref_a <= W'(ra_w); ref_b <= W'(rb_w); ref_c <= W'(rc_w);
          st    <= ST_FLAG;
        end
        ST_FLAG: begin
          out_valid <= 1'b1;
          st        <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srf_refgen_chk.sv
`timescale 1ns/1ps
module srf_refgen_chk #(
  parameter int W  = 16,
  parameter int IW = W + 6
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] ref_a,
  input logic signed [W-1:0] ref_b,
  input logic signed [W-1:0] ref_c,
  input logic signed [IW-1:0] loss_w,
  input logic [W-1:0]        pi_limit
);
  logic signed [IW-1:0] lim_s;
  assign lim_s = IW'(signed'({1'b0, pi_limit}));

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_accept_then_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(ref_a)
                                   && $stable(ref_b) && $stable(ref_c)));

  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  p_loss_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (loss_w <= lim_s) && (loss_w >= -lim_s));
endmodule

bind srf_refgen srf_refgen_chk #(.W(W), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
  .loss_w(loss_w), .pi_limit(pi_limit)
);

// File: tb/srf_refgen_tb.sv
`timescale 1ns/1ps
module srf_refgen_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [W-1:0] load_a = '0, load_b = '0, load_c = '0;
  logic signed [W-1:0] vdc_meas = '0, vdc_set = '0;
  logic signed [W-1:0] ang_cos = 16'sd16384, ang_sin = '0;
  logic [W-1:0] pi_limit = 16'd1000;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [W-1:0] ref_a, ref_b, ref_c;

  int n_run = 0;
  int n_fail = 0;

  longint m_hist [3];
  longint m_int;

  always #2.5 clk = ~clk;

  srf_refgen #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .load_a(load_a), .load_b(load_b), .load_c(load_c),
    .vdc_meas(vdc_meas), .vdc_set(vdc_set),
    .ang_cos(ang_cos), .ang_sin(ang_sin), .pi_limit(pi_limit),
    .out_valid(out_valid), .out_ready(out_ready),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint clip(input longint v, input longint hi, input longint lo);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // expected references from the requirement formulas
  task automatic model(input longint a, input longint b, input longint c,
                       input longint vd, input longint cs, input longint sn,
                       input longint vs, input longint lm,
                       output longint ea, output longint eb, output longint ec);
    longint al, be, z, d, q, mn, e, ls, dr, ar, br, h, r;
    al = (5456 * (2*a - b - c)) >>> 14;
    be = (9450 * (b - c)) >>> 14;
    z  = (5456 * (a + b + c)) >>> 14;
    d  = (cs*al + sn*be) >>> 14;
    q  = (cs*be - sn*al) >>> 14;
    mn = (1167 * (d + m_hist[2]) + 7025 * (m_hist[0] + m_hist[1])) >>> 14;
    m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = d;
    e  = vs - vd;
    m_int = clip(m_int + 19497*e, lm <<< 14, -(lm <<< 14));
    ls = clip((9830*e + m_int) >>> 14, lm, -lm);
    dr = d - mn - ls;
    ar = (cs*dr - sn*q) >>> 14;
    br = (sn*dr + cs*q) >>> 14;
    h  = ar >>> 1;
    r  = (14189 * br) >>> 14;
    ea = clip(z + ar, 32767, -32768);
    eb = clip(z - h + r, 32767, -32768);
    ec = clip(z - h - r, 32767, -32768);
  endtask

  task automatic do_reset(input int lim);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    pi_limit = W'(lim);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) m_hist[k] = 0;
    m_int = 0;
  endtask

  task automatic do_pass(input string tag, input int a, input int b, input int c,
                         input int vd, input int cs, input int sn, input int vs,
                         output int ra, output int rb, output int rc);
    longint ea, eb, ec;
    int lat;
    model(a, b, c, vd, cs, sn, vs, longint'(pi_limit), ea, eb, ec);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    load_a = W'(a); load_b = W'(b); load_c = W'(c);
    vdc_meas = W'(vd); vdc_set = W'(vs);
    ang_cos = W'(cs); ang_sin = W'(sn);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R3", "done latency", lat, 6);
    ra = int'(ref_a); rb = int'(ref_b); rc = int'(ref_c);
    check(tag, "ref_a", ra, ea);
    check(tag, "ref_b", rb, eb);
    check(tag, "ref_c", rc, ec);
  endtask

  task automatic t_reset_state();
    do_reset(1000);
    @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "in_ready after reset", in_ready, 1);
    check("R1", "ref_a after reset", ref_a, 0);
    check("R1", "ref_c after reset", ref_c, 0);
  endtask

  task automatic t_zero_seq();
    int ra, rb, rc;
    do_reset(1000);
    do_pass("R5", 3000, 3000, 3000, 0, 16384, 0, 0, ra, rb, rc);
    check("R5", "equal phases ref_a", ra, 2997);
    check("R5", "equal phases ref_b", rb, 2997);
    check("R5", "equal phases ref_c", rc, 2997);
  endtask

  task automatic t_dc_gain();
    int ra, rb, rc;
    do_reset(1000);
    for (int k = 0; k < 4; k++)
      do_pass("R7", 4000, -2000, -2000, 0, 16384, 0, 0, ra, rb, rc);
    check("R7", "constant d removed ref_a", ra, 0);
    check("R7", "constant d removed ref_b", rb, 0);
    check("R7", "constant d removed ref_c", rc, 0);
  endtask

  task automatic t_rotation();
    int ra, rb, rc;
    do_reset(1000);
    do_pass("R6", 1500, -700, 300, 0, 0, 16384, 0, ra, rb, rc);
    do_pass("R9", 1200, 400, -1600, 0, 11585, 11585, 0, ra, rb, rc);
    do_pass("R6", -900, 2500, -1100, 0, -11585, 11585, 0, ra, rb, rc);
    do_pass("R9", 2000, -1000, -1000, 0, 16384, 0, 0, ra, rb, rc);
  endtask

  task automatic t_pi_limit();
    int ra, rb, rc;
    do_reset(1000);
    for (int k = 0; k < 10; k++)
      do_pass("R8", 0, 0, 0, 400, 16384, 0, 500, ra, rb, rc);
    check("R8", "loss clamped at limit", ra, -1000);
    do_pass("R8", 0, 0, 0, 600, 16384, 0, 500, ra, rb, rc);
    check("R8", "loss leaves clamp at once", ra, -821);
  endtask

  task automatic t_saturate();
    int ra, rb, rc;
    do_reset(32767);
    do_pass("R10", -12000, -12000, -12000, -30000, 16384, 0, 30000, ra, rb, rc);
    check("R10", "ref_a clipped low", ra, -32768);
  endtask

  task automatic t_backpressure();
    int ra, rb, rc;
    do_reset(1000);
    out_ready = 1'b0;
    do_pass("R4", 2500, -500, -1500, 0, 16384, 0, 0, ra, rb, rc);
    for (int k = 0; k < 5; k++) begin
      load_a = 16'sd9000; load_b = -16'sd9000; load_c = 16'sd0;
      in_valid = 1'b1;
      @(negedge clk);
      check("R2", "in_ready low while held", in_ready, 0);
      check("R4", "out_valid held", out_valid, 1);
      check("R4", "ref_a held", ref_a, ra);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R4", "out_valid cleared on take", out_valid, 0);
    check("R4", "in_ready back", in_ready, 1);
    do_pass("R2", 2500, -500, -1500, 0, 16384, 0, 0, ra, rb, rc);
  endtask

  task automatic t_reset_clears();
    int ra, rb, rc;
    do_reset(1000);
    for (int k = 0; k < 3; k++)
      do_pass("R1", 3000, -1000, -2000, 100, 16384, 0, 500, ra, rb, rc);
    do_reset(1000);
    do_pass("R1", 3000, -1000, -2000, 100, 16384, 0, 500, ra, rb, rc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_zero_seq();
    t_dc_gain();
    t_rotation();
    t_pi_limit();
    t_saturate();
    t_backpressure();
    t_reset_clears();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule